// File: doc/BRIEF.md
# Frame-Buffer Word Unpacker

The unpacker sits between a frame-buffer fetch path and a display pixel pipeline. It accepts 32-bit words carrying packed pixels over a valid/ready input. It hands out one pixel per transfer over a valid/ready output, decoding each word according to a 3-bit format code. Two further controls set the extraction order inside the word: one for byte order and one for the order of sub-byte pixels within a byte.

For depths of 8 bits or fewer, the output is a palette index. For the direct-colour formats, each colour field is widened to 8 bits by copying its top bits into the low bits. The result is a 24-bit RGB value, and red and blue can optionally be exchanged.

The format and order controls may change only while no word is held. A synchronous flush drops a partly consumed word.

Top module: `fb_word_unpacker`

## Requirements
- R1: The format code selects the pixel container and the number of pixels per word. Code 0 gives 1-bit pixels (32 per word), 1 gives 2-bit (16), 2 gives 4-bit (8) and 3 gives 8-bit (4). Code 4 gives 5:5:5 colour in a 16-bit container (2), 5 gives 24-bit colour in a 32-bit container (1), 6 gives 5:6:5 (2) and 7 gives 4:4:4 in a 16-bit container (2).
- R2: With both order controls low, pixel k of a word is taken from bits starting at k times the container width, so the first pixel comes from the least significant end.
- R3: With byte order high, containers of 8 bits or more are taken from the most significant end of the word first. For narrower pixels, bytes are visited from byte 3 down to byte 0.
- R4: With pixel order high, sub-byte pixels within a byte are taken from the most significant end of the byte first. This control has no effect for containers of 8 bits or more.
- R5: In formats 0 to 3, out_index carries the pixel field zero-extended and out_rgb is zero.
- R6: In the colour formats, out_rgb is {red, green, blue}, 8 bits each, and out_index is zero. The field positions, from the least significant bit upward, are: 5:5:5 red[4:0], green[9:5], blue[14:10]; 5:6:5 red[4:0], green[10:5], blue[15:11]; 4:4:4 red[3:0], green[7:4], blue[11:8]; 24-bit red[7:0], green[15:8], blue[23:16], with bits 31:24 ignored. A field narrower than 8 bits is extended by repeating its most significant bits below it.
- R7: With the colour-swap control high, the red and blue bytes of out_rgb are exchanged in colour formats. The control has no effect on index formats.
- R8: While out_valid is high and out_ready is low, out_valid, out_index and out_rgb hold their values.
- R9: in_ready is high only when no word is held, or when the last pixel of the held word is being taken in the same cycle, and never while flush is high.
- R10: A flush drops any held word, so out_valid is low in the cycle after it.
- R11: After reset, out_valid is low, out_index and out_rgb are zero, and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of the held word |
| cfg_fmt | input | 3 | Pixel format code |
| cfg_byte_be | input | 1 | Take the word's most significant containers or bytes first |
| cfg_pix_be | input | 1 | Take a byte's most significant sub-byte pixels first |
| cfg_bgr | input | 1 | Exchange red and blue in colour formats |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| in_word | input | 32 | Packed frame-buffer word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_index | output | 8 | Palette index in formats 0 to 3 |
| out_rgb | output | 24 | Colour value {R,G,B} in formats 4 to 7 |

## Verification
The bench builds the block with its package defaults: a 32-bit word, 8-bit colour channels and an 8-bit index. These values reach every format, from 32 one-bit pixels per word down to one pixel per word. The random sweep therefore passes through the last-pixel index of every pixel count, with and without a new word waiting in the same cycle. Every combination of the two order controls and the colour swap is applied to all eight formats. The random consumer stalls exercise output hold at each pixel position.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam int CH_W   = 8;
    localparam int RGB_W  = 3 * CH_W;
    localparam int IDX_W  = 8;
    localparam int RAW_W  = RGB_W;

    typedef enum logic [2:0] {
        FMT_1   = 3'd0,
        FMT_2   = 3'd1,
        FMT_4   = 3'd2,
        FMT_8   = 3'd3,
        FMT_555 = 3'd4,
        FMT_24  = 3'd5,
        FMT_565 = 3'd6,
        FMT_444 = 3'd7
    } pix_fmt_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic [IDX_W-1:0] index;
        rgb_t             rgb;
    } pix_t;

    // log2 of the container width in bits
    function automatic int cont_log2(pix_fmt_e f);
        case (f)
            FMT_1:   return 0;
            FMT_2:   return 1;
            FMT_4:   return 2;
            FMT_8:   return 3;
            FMT_24:  return 5;
            default: return 4;
        endcase
    endfunction

    // meaningful data bits inside the container
    function automatic int data_bits(pix_fmt_e f);
        case (f)
            FMT_1:   return 1;
            FMT_2:   return 2;
            FMT_4:   return 4;
            FMT_8:   return 8;
            FMT_555: return 15;
            FMT_24:  return 24;
            FMT_565: return 16;
            default: return 12;
        endcase
    endfunction

    function automatic logic is_index(pix_fmt_e f);
        return (f == FMT_1) || (f == FMT_2) || (f == FMT_4) || (f == FMT_8);
    endfunction

    function automatic logic [CH_W-1:0] widen5(logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [CH_W-1:0] widen6(logic [5:0] v);
        return {v, v[5:4]};
    endfunction

    function automatic logic [CH_W-1:0] widen4(logic [3:0] v);
        return {v, v};
    endfunction

endpackage

// File: rtl/fbu_extract.sv
module fbu_extract
    import fbu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  pix_fmt_e          fmt,
    input  logic              byte_be,
    input  logic              pix_be,
    input  logic [CNT_W-1:0]  slot_idx,
    output logic [RAW_W-1:0]  raw
);
    int lg;
    int per_word;
    int per_byte;
    int byte_i;
    int sub_i;
    int byte_sel;
    int sub_sel;
    int bit_off;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        lg       = cont_log2(fmt);
        per_word = WORD_W >> lg;
        per_byte = 8 >> lg;
        byte_i   = 0;
        sub_i    = 0;
        byte_sel = 0;
        sub_sel  = 0;
        if (lg < 3) begin
            byte_i   = int'(slot_idx) >> (3 - lg);
            sub_i    = int'(slot_idx) % per_byte;
            byte_sel = byte_be ? (WORD_W / 8 - 1 - byte_i) : byte_i;
            sub_sel  = pix_be ? (per_byte - 1 - sub_i) : sub_i;
            bit_off  = byte_sel * 8 + (sub_sel << lg);
        end else begin
            bit_off  = (byte_be ? (per_word - 1 - int'(slot_idx)) : int'(slot_idx)) << lg;
        end
        mask    = WORD_W'((64'd1 << data_bits(fmt)) - 64'd1);
        shifted = word >> bit_off;
        raw     = RAW_W'(shifted & mask);
    end

endmodule

// File: rtl/fbu_colour.sv
module fbu_colour
    import fbu_pkg::*;
(
    input  logic [RAW_W-1:0] raw,
    input  pix_fmt_e         fmt,
    input  logic             bgr,
    output pix_t             pix
);
    rgb_t direct;

    always_comb begin
        direct = '0;
        case (fmt)
            FMT_555: begin
                direct.r = widen5(raw[4:0]);
                direct.g = widen5(raw[9:5]);
                direct.b = widen5(raw[14:10]);
            end
            FMT_565: begin
                direct.r = widen5(raw[4:0]);
                direct.g = widen6(raw[10:5]);
                direct.b = widen5(raw[15:11]);
            end
            FMT_444: begin
                direct.r = widen4(raw[3:0]);
                direct.g = widen4(raw[7:4]);
                direct.b = widen4(raw[11:8]);
            end
            FMT_24: begin
                direct.r = raw[7:0];
                direct.g = raw[15:8];
                direct.b = raw[23:16];
            end
            default: direct = '0;
        endcase

        pix = '0;
        if (is_index(fmt)) begin
            pix.index = raw[IDX_W-1:0];
        end else if (bgr) begin
            pix.rgb.r = direct.b;
            pix.rgb.g = direct.g;
            pix.rgb.b = direct.r;
        end else begin
            pix.rgb = direct;
        end
    end

endmodule

// File: rtl/fb_word_unpacker.sv
module fb_word_unpacker
    import fbu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [2:0]        cfg_fmt,
    input  logic              cfg_byte_be,
    input  logic              cfg_pix_be,
    input  logic              cfg_bgr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [IDX_W-1:0]  out_index,
    output logic [RGB_W-1:0]  out_rgb
);
    pix_fmt_e           fmt;
    logic [WORD_W-1:0]  word_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               full_q;
    logic [CNT_W:0]     ppw;
    logic               last;
    logic               take;
    logic               accept;
    logic [RAW_W-1:0]   raw;
    pix_t               pix;

    assign fmt    = pix_fmt_e'(cfg_fmt);
    assign ppw    = (CNT_W+1)'(WORD_W >> cont_log2(fmt));
    assign last   = ({1'b0, cnt_q} == (ppw - 1'b1));
    assign take   = full_q & out_ready;
    assign in_ready = ~flush & (~full_q | (out_ready & last));
    assign accept = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else if (flush) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else if (accept) begin
            word_q <= in_word;
            cnt_q  <= '0;
            full_q <= 1'b1;
        end else if (take) begin
            if (last) begin
                full_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    fbu_extract i_extract (
        .word     (word_q),
        .fmt      (fmt),
        .byte_be  (cfg_byte_be),
        .pix_be   (cfg_pix_be),
        .slot_idx (cnt_q),
        .raw      (raw)
    );

    fbu_colour i_colour (
        .raw (raw),
        .fmt (fmt),
        .bgr (cfg_bgr),
        .pix (pix)
    );

    assign out_valid = full_q;
    assign out_index = full_q ? pix.index : '0;
    assign out_rgb   = full_q ? pix.rgb   : '0;

    AST_CNT_IN_WORD: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ({1'b0, cnt_q} < ppw)); // R1

    AST_INDEX_NO_RGB: assert property (@(posedge clk) disable iff (rst)
        (out_valid && is_index(fmt)) |-> (out_rgb == '0)); // R5

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !flush) |=>
            (out_valid && $stable(out_index) && $stable(out_rgb))); // R8

    AST_ACCEPT_AT_END: assert property (@(posedge clk) disable iff (rst)
        (in_ready && out_valid) |-> out_ready); // R9

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_valid); // R10

endmodule

// File: tb/test_fb_word_unpacker.sv
module test_fb_word_unpacker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic [2:0]  cfg_fmt = 3'd0;
    logic        cfg_byte_be = 1'b0;
    logic        cfg_pix_be = 1'b0;
    logic        cfg_bgr = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_index;
    logic [23:0] out_rgb;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fb_word_unpacker i_fb_word_unpacker (
        .clk(clk), .rst(rst), .flush(flush),
        .cfg_fmt(cfg_fmt), .cfg_byte_be(cfg_byte_be), .cfg_pix_be(cfg_pix_be), .cfg_bgr(cfg_bgr),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_index(out_index), .out_rgb(out_rgb)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int pix_count(int f);
        case (f)
            0: return 32;
            1: return 16;
            2: return 8;
            3: return 4;
            5: return 1;
            default: return 2;
        endcase
    endfunction

    // expected {index, rgb} for pixel k of word w
    function automatic logic [31:0] model(logic [31:0] w, int f, bit bbe, bit pbe, bit bgr, int k);
        int bits;
        int per;
        int bi;
        int j;
        int sh;
        logic [7:0]  by;
        logic [31:0] v;
        logic [7:0]  r, g, b;
        bits = 32 / pix_count(f);
        if (bits < 8) begin
            per = 8 / bits;
            bi  = k / per;
            j   = k % per;
            by  = w[8*(bbe ? 3 - bi : bi) +: 8];
            sh  = pbe ? 8 - bits * (j + 1) : bits * j;
            v   = 32'((by >> sh) & ((1 << bits) - 1));
        end else begin
            v = w >> (bits * (bbe ? pix_count(f) - 1 - k : k));
        end
        r = 0; g = 0; b = 0;
        case (f)
            0, 1, 2, 3: return {v[7:0], 24'h0};
            4: begin r = {v[4:0], v[4:2]};   g = {v[9:5], v[9:7]};   b = {v[14:10], v[14:12]}; end
            6: begin r = {v[4:0], v[4:2]};   g = {v[10:5], v[10:9]}; b = {v[15:11], v[15:13]}; end
            7: begin r = {v[3:0], v[3:0]};   g = {v[7:4], v[7:4]};   b = {v[11:8], v[11:8]};   end
            default: begin r = v[7:0]; g = v[15:8]; b = v[23:16]; end
        endcase
        return bgr ? {8'h0, b, g, r} : {8'h0, r, g, b};
    endfunction

    // stream nw random words through one configuration with random stalls
    task automatic run_cfg(input int f, input bit bbe, input bit pbe, input bit bgr, input int nw);
        logic [31:0] expq[$];
        int sent;
        bit stalled;
        logic [31:0] held;
        sent = 0;
        stalled = 0;
        held = '0;
        cfg_fmt = 3'(f); cfg_byte_be = bbe; cfg_pix_be = pbe; cfg_bgr = bgr;
        in_word = $urandom();
        while (sent < nw || expq.size() != 0) begin
            if (stalled) // R8 output held while stalled
                chk(out_valid && {out_index, out_rgb} == held, "R8", {out_index, out_rgb}, held);
            out_ready = ($urandom() % 4) != 0;
            in_valid  = (sent < nw) && (($urandom() % 3) != 0);
            #1;
            stalled = out_valid && !out_ready;
            held = {out_index, out_rgb};
            if (out_valid && out_ready) begin
                if (expq.size() == 0)
                    chk(1'b0, "R9", 32'h1, 32'h0);
                else
                    chk({out_index, out_rgb} == expq[0],
                        f < 4 ? (bbe || pbe ? "R3/R4 R5" : "R2 R5") : (bgr ? "R6 R7" : "R6"),
                        {out_index, out_rgb}, expq[0]);
                if (expq.size() != 0) void'(expq.pop_front());
            end
            if (out_valid && in_ready) // R9
                chk(out_ready && expq.size() == 0, "R9", 32'(expq.size()), 32'h0);
            if (in_valid && in_ready) begin
                for (int k = 0; k < pix_count(f); k++)
                    expq.push_back(model(in_word, f, bbe, pbe, bgr, k));
                sent++;
            end
            @(negedge clk);
            if (in_valid && sent > 0) in_word = $urandom();
        end
        in_valid = 1'b0;
        out_ready = 1'b0;
        #1;
        chk(!out_valid, "R1", 32'(out_valid), 32'h0);
    endtask

    // load one word with the consumer stalled and return the first pixel
    task automatic probe(input int f, input bit bbe, input bit pbe, input bit bgr,
                         input logic [31:0] w, output logic [31:0] first);
        cfg_fmt = 3'(f); cfg_byte_be = bbe; cfg_pix_be = pbe; cfg_bgr = bgr;
        out_ready = 1'b0;
        in_word = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        first = {out_index, out_rgb};
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        logic [31:0] p;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        chk(!out_valid, "R11", 32'(out_valid), 32'h0);
        chk(in_ready, "R11", 32'(in_ready), 32'h1);
        chk({out_index, out_rgb} == 32'h0, "R11", {out_index, out_rgb}, 32'h0);
        @(negedge clk);

        probe(1, 0, 0, 0, 32'h0000_0003, p);
        chk(p == 32'h0300_0000, "R2", p, 32'h0300_0000);
        probe(3, 1, 0, 0, 32'h1122_3344, p);
        chk(p == 32'h1100_0000, "R3", p, 32'h1100_0000);
        probe(0, 0, 1, 0, 32'h0000_0080, p);
        chk(p == 32'h0100_0000, "R4", p, 32'h0100_0000);
        probe(3, 0, 1, 0, 32'h1122_3344, p);
        chk(p == 32'h4400_0000, "R4", p, 32'h4400_0000);
        probe(6, 0, 0, 0, 32'h0000_FFFF, p);
        chk(p == 32'h00FF_FFFF, "R6", p, 32'h00FF_FFFF);
        probe(7, 0, 0, 0, 32'h0000_0F00, p);
        chk(p == 32'h0000_00FF, "R6", p, 32'h0000_00FF);
        probe(7, 0, 0, 1, 32'h0000_0F00, p);
        chk(p == 32'h00FF_0000, "R7", p, 32'h00FF_0000);
        probe(3, 0, 0, 1, 32'h0000_00A5, p);
        chk(p == 32'hA500_0000, "R7", p, 32'hA500_0000);
        probe(5, 0, 0, 0, 32'hEE33_2211, p);
        chk(p == 32'h0011_2233, "R6", p, 32'h0011_2233);

        // R10 flush discards a partly consumed word
        cfg_fmt = 3'd3; cfg_byte_be = 0; cfg_pix_be = 0; cfg_bgr = 0;
        in_word = 32'hA1B2_C3D4; in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0; flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        #1;
        chk(!out_valid, "R10", 32'(out_valid), 32'h0);
        in_word = 32'h0000_0055; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk({out_index, out_rgb} == 32'h5500_0000, "R10", {out_index, out_rgb}, 32'h5500_0000);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;

        // R1 sweep of all formats and orderings
        for (int f = 0; f < 8; f++)
            for (int o = 0; o < 8; o++)
                run_cfg(f, o[0], o[1], o[2], 3);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %h expected %h", 32'h1, 32'h0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule